// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

The arbiter collects a processor reset request, one nonmaskable interrupt and twelve maskable interrupt lines (numbers 4 to 15). It picks one request per cycle, emits a one-cycle acknowledge strobe and reports the 4-bit number of the serviced request. Maskable requests are remembered as flag bits, set by a rising edge on their line or by software. Software reaches the flags, the per-line enables and a control word (global enable, NMI enable) through a write port and a combinational read port.

A small state machine tracks the reset request line. RUN is the normal arbitrating state. RUN goes to RST_COUNT when the reset request line is sampled low. RST_COUNT returns to RUN if the line is sampled high before the hold time expires. RST_COUNT goes to RST_HELD on the tenth consecutive low sample, and in that transition the reset request is serviced. RST_HELD returns to RUN once the line is sampled high. Arbitration of NMI and maskable requests happens only in RUN.

Top module: `irq_arbiter`

## Requirements
- R1: After the block reset `sys_rst_n`, every readable register reads 0, `int_ack` is 0 and `int_num` is 0.
- R2: A rising edge on `irq_in[k]` sets the flag of interrupt k+4 (flag read bit k+4), and a rising edge on `nmi_in` sets the NMI flag (flag read bit 1). A line held high does not set its flag again after the flag is cleared.
- R3: A write to address 2 (set) sets each maskable flag whose data bit (4..15) is 1. Bits that are 0 leave their flags unchanged, and data bits 0..3 have no effect; in particular they do not change the NMI flag.
- R4: A write to address 3 (clear) clears each maskable flag whose data bit is 1. Bits that are 0 have no effect, and the NMI flag is never changed by it.
- R5: If a flag is set (edge or set write) and cleared in the same cycle, the flag ends up set.
- R6: A maskable interrupt is taken only when global enable (control bit 0), NMI enable (control bit 1), its enable bit (address 1, bits 4..15) and its flag are all 1. The acknowledge appears on the clock edge after the flag and enables are all 1.
- R7: Among the maskable interrupts that are pending and enabled, the lowest number is taken.
- R8: Taking a maskable interrupt clears its flag and the global enable bit on the same edge that raises `int_ack`.
- R9: A pending NMI is taken, with number 1, when NMI enable is 1, and its flag is then cleared. NMI outranks every maskable request, does not clear global enable, and with NMI enable 0 no maskable interrupt is taken.
- R10: The reset request is serviced (number 0) on the edge of the tenth consecutive low sample of `cpu_rst_n`, and all flags, enables and control bits then return to 0. A shorter low pulse changes nothing. While the line is low no other request is taken, and a pending request is taken on the second edge after the line goes high.
- R11: The register map is: address 0 holds the flags (read only; writes ignored), address 1 holds the enables (bits 0..3 read 0), address 4 holds the control word. Addresses 2, 3 and all others read 0.
- R12: `int_ack` is high for one cycle per serviced request, and `int_num` is 0 whenever `int_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Asynchronous active-low block reset |
| cpu_rst_n | input | 1 | Active-low processor reset request, arbitrated at top priority |
| nmi_in | input | 1 | Nonmaskable interrupt line, active high |
| irq_in | input | 12 | Maskable lines; bit k is interrupt k+4 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| int_ack | output | 1 | One-cycle acknowledge of a serviced request |
| int_num | output | 4 | Number of the serviced request while `int_ack` is high |

## Verification
The hardest situation to reach is a collision: a rising edge landing on the same edge as a clear write, or a pending NMI and a pending maskable request becoming eligible on the same edge when one control write enables both. The bench reaches them by first parking requests while enables are off, then releasing them with a single write. The reset request path is driven with pulses one cycle short of and exactly at the hold time. A maskable request is posted during the short pulse, so the deferred take and its exact cycle after release can be observed.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_RST_COUNT,
        ST_RST_HELD
    } arb_state_t;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_FLAG = 3'd0;
    localparam logic [REG_AW-1:0] A_EN   = 3'd1;
    localparam logic [REG_AW-1:0] A_SET  = 3'd2;
    localparam logic [REG_AW-1:0] A_CLR  = 3'd3;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd4;

endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= level_i[g];
        end
        assign rise_o[g] = level_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned W = 12,
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 16,
    parameter int unsigned FIRST_MASK = 4,
    parameter int unsigned NMI_NUM    = 1,
    parameter int unsigned RST_HOLD   = 10
) (
    input  logic                              clk,
    input  logic                              sys_rst_n,
    input  logic                              cpu_rst_n,
    input  logic                              nmi_in,
    input  logic [NUM_LINES-FIRST_MASK-1:0]   irq_in,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_addr,
    input  logic [NUM_LINES-1:0]              wr_data,
    input  logic [2:0]                        rd_addr,
    output logic [NUM_LINES-1:0]              rd_data,
    output logic                              int_ack,
    output logic [$clog2(NUM_LINES)-1:0]      int_num
);
    localparam int unsigned MASK_CNT = NUM_LINES - FIRST_MASK;
    localparam int unsigned NUM_W    = $clog2(NUM_LINES);
    localparam int unsigned IDX_W    = (MASK_CNT > 1) ? $clog2(MASK_CNT) : 1;
    localparam int unsigned CNT_W    = $clog2(RST_HOLD + 1);

    arb_state_t           state;
    logic [CNT_W-1:0]     low_cnt;
    logic [MASK_CNT-1:0]  mflag, ie, mrise, wr_set, wr_clr, take_vec;
    logic                 nflag, nrise, gie, nmie;
    logic [MASK_CNT:0]    rise_all;
    logic                 pick_any;
    logic [IDX_W-1:0]     pick_idx;
    logic                 arb_live, nmi_take, mask_take, rst_take;
    logic                 unused_wr_bits;

    assign unused_wr_bits = ^wr_data[FIRST_MASK-1:2];

    irq_edge #(.W(MASK_CNT + 1)) u_edge (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .level_i ({irq_in, nmi_in}),
        .rise_o  (rise_all)
    );
    assign mrise = rise_all[MASK_CNT:1];
    assign nrise = rise_all[0];

    irq_pick #(.W(MASK_CNT)) u_pick (
        .req_i (mflag & ie),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    assign wr_set = (wr_en && wr_addr == A_SET) ? wr_data[NUM_LINES-1:FIRST_MASK] : '0;
    assign wr_clr = (wr_en && wr_addr == A_CLR) ? wr_data[NUM_LINES-1:FIRST_MASK] : '0;

    assign arb_live  = (state == ST_RUN);
    assign nmi_take  = arb_live && nmie && nflag;
    assign mask_take = arb_live && !nmi_take && gie && nmie && pick_any;
    assign rst_take  = (state == ST_RST_COUNT) && !cpu_rst_n
                       && (low_cnt == CNT_W'(RST_HOLD - 1));

    always_comb begin
        for (int i = 0; i < int'(MASK_CNT); i++)
            take_vec[i] = mask_take && (pick_idx == IDX_W'(i));
    end

    // state register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state   <= ST_RUN;
            low_cnt <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (!cpu_rst_n) begin
                        state   <= ST_RST_COUNT;
                        low_cnt <= CNT_W'(1);
                    end
                end
                ST_RST_COUNT: begin
                    if (cpu_rst_n)     state   <= ST_RUN;
                    else if (rst_take) state   <= ST_RST_HELD;
                    else               low_cnt <= low_cnt + CNT_W'(1);
                end
                ST_RST_HELD: begin
                    if (cpu_rst_n) state <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            int_ack <= 1'b0;
            int_num <= '0;
        end else begin
            int_ack <= rst_take || nmi_take || mask_take;
            if (rst_take)       int_num <= '0;
            else if (nmi_take)  int_num <= NUM_W'(NMI_NUM);
            else if (mask_take) int_num <= NUM_W'(pick_idx) + NUM_W'(FIRST_MASK);
            else                int_num <= '0;
        end
    end

    // flag, enable and control storage
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            mflag <= '0;
            nflag <= 1'b0;
            ie    <= '0;
            gie   <= 1'b0;
            nmie  <= 1'b0;
        end else if (rst_take) begin
            mflag <= '0;
            nflag <= 1'b0;
            ie    <= '0;
            gie   <= 1'b0;
            nmie  <= 1'b0;
        end else begin
            mflag <= (mflag & ~wr_clr & ~take_vec) | mrise | wr_set;
            nflag <= (nflag & ~nmi_take) | nrise;
            if (wr_en && wr_addr == A_EN)
                ie <= wr_data[NUM_LINES-1:FIRST_MASK];
            if (wr_en && wr_addr == A_CTRL) begin
                gie  <= wr_data[0];
                nmie <= wr_data[1];
            end
            if (mask_take) gie <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_FLAG: begin
                rd_data[NUM_LINES-1:FIRST_MASK] = mflag;
                rd_data[NMI_NUM]                = nflag;
            end
            A_EN:   rd_data[NUM_LINES-1:FIRST_MASK] = ie;
            A_CTRL: begin
                rd_data[0] = gie;
                rd_data[1] = nmie;
            end
            default: rd_data = '0;
        endcase
    end

    // R6: a maskable acknowledge needs both global and NMI enable the cycle before
    p_mask_gates_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (int_ack && int_num >= NUM_W'(FIRST_MASK)) |-> $past(gie && nmie));

    // R8: global enable is already low when the maskable acknowledge appears
    p_gie_cleared_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (int_ack && int_num >= NUM_W'(FIRST_MASK)) |-> !gie);

    // R9: an NMI acknowledge requires NMI enable the cycle before
    p_nmi_enabled_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (int_ack && int_num == NUM_W'(NMI_NUM)) |-> $past(nmie));

    // R10: servicing reset leaves enables and control cleared and the FSM held
    p_rst_defaults_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (int_ack && int_num == '0) |-> (ie == '0 && !gie && !nmie && state == ST_RST_HELD));

    // R12: number output is quiet without acknowledge
    p_num_idle_r12: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !int_ack |-> int_num == '0);

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
    localparam logic [2:0] A_FLAG = 3'd0, A_EN = 3'd1, A_SET = 3'd2,
                           A_CLR = 3'd3, A_CTRL = 3'd4;

    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        cpu_rst_n = 1'b1;
    logic        nmi_in = 1'b0;
    logic [11:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        int_ack;
    logic [3:0]  int_num;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .cpu_rst_n(cpu_rst_n),
        .nmi_in(nmi_in), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .int_ack(int_ack), .int_num(int_num)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic cleanup();
        wr(A_CLR, 16'hFFFF);
        wr(A_CTRL, 16'h0000);
        wr(A_EN, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) tick();
        sys_rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 ack", int_ack, 0);
        check("R1 num", int_num, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 0);
        end

        // R11 register map
        wr(A_FLAG, 16'hFFFF);
        rd(A_FLAG, v); check("R11 flag write ignored", v, 16'h0000);
        wr(A_EN, 16'hFFFF);
        rd(A_EN, v);   check("R11 enable low bits", v, 16'hFFF0);
        rd(A_SET, v);  check("R11 set reads 0", v, 0);
        rd(A_CLR, v);  check("R11 clear reads 0", v, 0);
        wr(A_CTRL, 16'hFFFC);
        rd(A_CTRL, v); check("R11 ctrl bits", v, 16'h0000);
        wr(A_EN, 16'h0000);

        // R2 edge on line 3 (interrupt 7), level held
        irq_in[3] = 1'b1; tick();
        rd(A_FLAG, v); check("R2 edge sets", v, 16'h0080);
        wr(A_CLR, 16'h0080); tick(); tick();
        rd(A_FLAG, v); check("R2 level no reset", v, 16'h0000);
        irq_in[3] = 1'b0; tick();
        irq_in[3] = 1'b1; tick();
        rd(A_FLAG, v); check("R2 second edge", v, 16'h0080);
        irq_in[3] = 1'b0;

        // R3 / R4 bit-wise set and clear
        wr(A_SET, 16'h0A00);
        rd(A_FLAG, v); check("R3 set ones only", v, 16'h0A80);
        wr(A_CLR, 16'h0200);
        rd(A_FLAG, v); check("R4 clear ones only", v, 16'h0880);
        cleanup();

        // R5 edge and clear collide on interrupt 6
        irq_in[2] = 1'b1;
        wr(A_CLR, 16'h0040);
        rd(A_FLAG, v); check("R5 set wins", v, 16'h0040);
        irq_in[2] = 1'b0;
        cleanup();

        // R2 / R3 / R4 / R9 NMI flag
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        rd(A_FLAG, v); check("R2 nmi edge", v, 16'h0002);
        wr(A_SET, 16'h000F);
        rd(A_FLAG, v); check("R3 low bits no effect", v, 16'h0002);
        wr(A_CLR, 16'h000F);
        rd(A_FLAG, v); check("R4 nmi untouched", v, 16'h0002);
        check("R9 no take disabled", int_ack, 0);
        wr(A_CTRL, 16'h0002);
        tick();
        check("R9 nmi ack", int_ack, 1);
        check("R9 nmi num", int_num, 1);
        rd(A_FLAG, v); check("R9 nmi flag cleared", v, 16'h0000);
        tick();
        check("R12 one-cycle ack", int_ack, 0);
        check("R12 num idle", int_num, 0);
        cleanup();

        // R9 NMI beats maskable, maskable follows
        wr(A_EN, 16'hFFF0);
        wr(A_CTRL, 16'h0001);
        wr(A_SET, 16'h0010);
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        check("R9 nmi gates maskable", int_ack, 0);
        wr(A_CTRL, 16'h0003);
        tick();
        check("R9 nmi first ack", int_ack, 1);
        check("R9 nmi first num", int_num, 1);
        tick();
        check("R9 maskable next ack", int_ack, 1);
        check("R9 maskable next num", int_num, 4);
        cleanup();

        // R6 gating sweep on interrupt 6
        for (int c = 0; c < 16; c++) begin
            logic g, n, e, f;
            g = c[0]; n = c[1]; e = c[2]; f = c[3];
            wr(A_EN, e ? 16'h0040 : 16'h0000);
            wr(A_CTRL, {14'b0, n, g});
            if (f) wr(A_SET, 16'h0040);
            else   wr(3'd7, 16'h0040);
            tick();
            check("R6 gate ack", int_ack, 32'(g & n & e & f));
            check("R6 gate num", int_num, (g & n & e & f) ? 6 : 0);
            cleanup();
        end

        // R7 / R8 pair sweep
        wr(A_EN, 16'hFFF0);
        wr(A_CTRL, 16'h0003);
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                logic [15:0] pair;
                int lo;
                pair = (16'h1 << (i + 4)) | (16'h1 << (j + 4));
                lo = (i < j) ? i : j;
                wr(A_SET, pair);
                tick();
                check("R7 ack", int_ack, 1);
                check("R7 lowest num", int_num, lo + 4);
                rd(A_FLAG, v);
                check("R8 winner flag cleared", v, pair & ~(16'h1 << (lo + 4)));
                rd(A_CTRL, v);
                check("R8 gie cleared", v, 16'h0002);
                wr(A_CLR, 16'hFFFF);
                check("R12 single ack", int_ack, 0);
                wr(A_CTRL, 16'h0003);
            end
        end
        cleanup();

        // R10 short pulse with a deferred request
        wr(A_EN, 16'hFFF0);
        wr(A_CTRL, 16'h0003);
        cpu_rst_n = 1'b0;
        for (int t = 1; t <= 9; t++) begin
            if (t == 4) wr(A_SET, 16'h0010);
            else        tick();
            check("R10 no take while low", int_ack, 0);
        end
        cpu_rst_n = 1'b1;
        tick();
        check("R10 not yet", int_ack, 0);
        tick();
        check("R10 deferred ack", int_ack, 1);
        check("R10 deferred num", int_num, 4);
        rd(A_EN, v); check("R10 short pulse keeps enables", v, 16'hFFF0);

        // R10 full pulse
        wr(A_CTRL, 16'h0003);
        cpu_rst_n = 1'b0;
        for (int t = 1; t <= 9; t++) begin
            if (t == 3) wr(A_SET, 16'h0200);
            else        tick();
            check("R10 before hold", int_ack, 0);
        end
        tick();
        check("R10 reset ack", int_ack, 1);
        check("R10 reset num", int_num, 0);
        rd(A_EN, v);   check("R10 enables cleared", v, 0);
        rd(A_CTRL, v); check("R10 ctrl cleared", v, 0);
        rd(A_FLAG, v); check("R10 flags cleared", v, 0);
        tick();
        check("R10 held no ack", int_ack, 0);
        cpu_rst_n = 1'b1;
        tick(); tick();
        check("R12 quiet after", int_ack, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule